// File: doc/BRIEF.md
# Event-to-Channel Dispatch Matrix

This block turns peripheral request events into pending flags on DMA channels. Each event has its own routing word, one bit per channel. When the event fires, every channel whose bit is set in that word gets its pending flag raised in the same clock. A channel engine that finishes its work drops its own pending flag through a clear command input. If an event tries to raise a pending flag that is still up, the block treats it as an overrun. It keeps that overrun as a sticky error bit for the channel.

The host sees the block through a small synchronous register bus. Through it the host loads the routing words, reads the pending flags and reads the error flags. Reading the error flags also clears them. The host also sets a per-channel error mask. The masked errors combine into one interrupt request. Two of the event lines come from device pins. They are synchronized first and produce an event only on a rising edge. The routing words are not reset, so software must load all of them before any event source is turned on.

Top module: `evdisp_matrix`

## Requirements
- R1: After reset the pending flags, error flags and mask are all zero, `irq_o` is low and `bus_rdata_o` is zero.
- R2: A bus write to address e (0 to 47) stores a 32-bit routing word for event e. A read of address e returns that word one clock after `bus_rd_i` is sampled.
- R3: A one-cycle pulse on `evt_i[e]` raises the pending flag of every channel i whose bit i is 1 in routing word e. The flags are visible after that clock edge. Channels whose bit is 0 are unchanged.
- R4: When an event hits channel i while its pending flag is already 1, error bit i becomes 1 and the pending flag stays 1. A hit on a channel whose flag is 0 latches no error.
- R5: Reading address 0x41 returns the error flags and clears them in the same clock. Until that read, error bits stay set.
- R6: If a new error arises in the same clock as a read of address 0x41, the read returns only the older bits and the new bit stays latched afterwards.
- R7: Address 0x42 is a read/write mask. `irq_o` is high exactly when some error bit i is 1 and mask bit i is 1.
- R8: With `clr_valid_i` high, the pending flag of channel `clr_ch_i` is cleared at the clock edge and no other channel changes.
- R9: If a clear and an event hit the same channel in one clock, the flag ends up 1. An error is latched only if the flag was 1 before that clock.
- R10: Pin j drives event 14+j. A rising pin raises pending at the third clock edge after the change. A pin held high fires only once, and a falling pin fires nothing.
- R11: Address 0x40 reads the pending flags, and `pend_o` shows them continuously.
- R12: Several events in one clock that all target the same channel while its flag is 0 raise the flag and latch no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 48 | Internal event pulses, one cycle each |
| pin_i | input | 2 | Asynchronous event pins, rising-edge triggered |
| clr_valid_i | input | 1 | Clear-pending command valid |
| clr_ch_i | input | 5 | Channel whose pending flag is cleared |
| bus_addr_i | input | 7 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 32 | Register write data |
| bus_rd_i | input | 1 | Register read strobe |
| bus_rdata_o | output | 32 | Read data, registered |
| pend_o | output | 32 | Channel pending flags |
| irq_o | output | 1 | Masked error interrupt request |

## Verification
The fan-out is driven with sparse, single-bit and dense routing words, and each tells apart a wrong word from a wrong bit. Single events, simultaneous events on one channel and events into already-pending channels separate a plain set from an overrun. A clear and an error read that collide with a set in the same clock show the priority between them. Pin stimuli that rise, hold and fall show the edge detector apart from level sensing, and they also pin down the three-clock latency.

// File: rtl/evdisp_pkg.sv
package evdisp_pkg;
  localparam int unsigned EVT_N    = 48;
  localparam int unsigned CH_N     = 32;
  localparam int unsigned PIN_N    = 2;
  localparam int unsigned PIN_BASE = 14;
  localparam int unsigned ADDR_W   = 7;
  localparam logic [ADDR_W-1:0] A_PEND = 7'h40;
  localparam logic [ADDR_W-1:0] A_ERR  = 7'h41;
  localparam logic [ADDR_W-1:0] A_MASK = 7'h42;
endpackage

// File: rtl/evdisp_pin_edge.sv
module evdisp_pin_edge #(
  parameter int unsigned PIN_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] pin_i,
  output logic [PIN_N-1:0] rise_o
);
  logic [PIN_N-1:0] s0_q, s1_q, prev_q;

  for (genvar j = 0; j < PIN_N; j++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s0_q[j]   <= 1'b0;
        s1_q[j]   <= 1'b0;
        prev_q[j] <= 1'b0;
      end else begin
        s0_q[j]   <= pin_i[j];
        s1_q[j]   <= s0_q[j];
        prev_q[j] <= s1_q[j];
      end
    end

    assign rise_o[j] = s1_q[j] & ~prev_q[j];

    // A rising edge yields a single-cycle pulse (R10)
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[j] |=> !rise_o[j]);
  end
endmodule

// File: rtl/evdisp_route_file.sv
module evdisp_route_file #(
  parameter int unsigned EVT_N = 48,
  parameter int unsigned CH_N  = 32,
  localparam int unsigned EW   = $clog2(EVT_N)
) (
  input  logic            clk,
  input  logic            wr_en_i,
  input  logic [EW-1:0]   wr_idx_i,
  input  logic [CH_N-1:0] wdata_i,
  input  logic [EW-1:0]   rd_idx_i,
  output logic [CH_N-1:0] rd_word_o,
  input  logic [EVT_N-1:0] evt_i,
  output logic [CH_N-1:0] hit_o
);
  logic [CH_N-1:0] word_q [EVT_N];

  for (genvar e = 0; e < EVT_N; e++) begin : g_word
    logic wr_sel;
    assign wr_sel = wr_en_i && (wr_idx_i == EW'(e));
    always_ff @(posedge clk) begin
      if (wr_sel) word_q[e] <= wdata_i;
    end
  end

  always_comb begin
    hit_o     = '0;
    rd_word_o = '0;
    for (int e = 0; e < EVT_N; e++) begin
      if (evt_i[e]) hit_o = hit_o | word_q[e];
      if (rd_idx_i == EW'(e)) rd_word_o = word_q[e];
    end
  end
endmodule

// File: rtl/evdisp_chan_state.sv
module evdisp_chan_state #(
  parameter int unsigned CH_N = 32,
  localparam int unsigned CW  = $clog2(CH_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_N-1:0] hit_i,
  input  logic            clr_valid_i,
  input  logic [CW-1:0]   clr_ch_i,
  input  logic            err_rd_clr_i,
  input  logic            mask_wr_i,
  input  logic [CH_N-1:0] mask_wdata_i,
  output logic [CH_N-1:0] pend_o,
  output logic [CH_N-1:0] err_o,
  output logic [CH_N-1:0] mask_o,
  output logic            irq_o
);
  logic [CH_N-1:0] pend_q, pend_d, err_q, err_d, mask_q, mask_d;
  logic [CH_N-1:0] clr_vec, ovr_vec;

  always_comb begin
    clr_vec = clr_valid_i ? (CH_N'(1) << clr_ch_i) : '0;
    ovr_vec = hit_i & pend_q;
    pend_d  = (pend_q & ~clr_vec) | hit_i;
    err_d   = (err_rd_clr_i ? '0 : err_q) | ovr_vec;
    mask_d  = mask_wr_i ? mask_wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      err_q  <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
      mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;
  assign mask_o = mask_q;
  assign irq_o  = |(err_q & mask_q);

  // Every hit channel is pending afterwards, even against a clear (R3, R9)
  assert_hit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((pend_q & $past(hit_i)) == $past(hit_i)));
  // Hit on a pending channel latches error (R4)
  assert_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_i & pend_q)) |=> ((err_q & $past(hit_i & pend_q)) == $past(hit_i & pend_q)));
  // Errors are sticky without a read (R5)
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_rd_clr_i |=> ((err_q & $past(err_q)) == $past(err_q)));
  // Pending falls only by a single-channel clear (R8)
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  assert_one_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones($past(pend_q) & ~pend_q) <= 1));
  // Interrupt needs some error (R7)
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (err_q != '0));
endmodule

// File: rtl/evdisp_matrix.sv
module evdisp_matrix
  import evdisp_pkg::*;
#(
  parameter int unsigned P_EVT_N = EVT_N,
  parameter int unsigned P_CH_N  = CH_N,
  parameter int unsigned P_PIN_N = PIN_N,
  parameter int unsigned P_PIN_BASE = PIN_BASE,
  localparam int unsigned EW = $clog2(P_EVT_N),
  localparam int unsigned CW = $clog2(P_CH_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_EVT_N-1:0] evt_i,
  input  logic [P_PIN_N-1:0] pin_i,
  input  logic               clr_valid_i,
  input  logic [CW-1:0]      clr_ch_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [P_CH_N-1:0]  bus_wdata_i,
  input  logic               bus_rd_i,
  output logic [P_CH_N-1:0]  bus_rdata_o,
  output logic [P_CH_N-1:0]  pend_o,
  output logic               irq_o
);
  logic [P_PIN_N-1:0] pin_rise;
  logic [P_EVT_N-1:0] evt_all;
  logic [P_CH_N-1:0]  hit, rd_word, err, mask;
  logic [P_CH_N-1:0]  rdata_d, rdata_q;
  logic               in_route, err_rd_clr, mask_wr;

  evdisp_pin_edge #(.PIN_N(P_PIN_N)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(pin_rise)
  );

  always_comb begin
    evt_all = evt_i;
    for (int j = 0; j < int'(P_PIN_N); j++) begin
      evt_all[P_PIN_BASE + j] = evt_i[P_PIN_BASE + j] | pin_rise[j];
    end
  end

  assign in_route   = bus_addr_i < ADDR_W'(P_EVT_N);
  assign err_rd_clr = bus_rd_i && (bus_addr_i == A_ERR);
  assign mask_wr    = bus_wr_i && (bus_addr_i == A_MASK);

  evdisp_route_file #(.EVT_N(P_EVT_N), .CH_N(P_CH_N)) u_route (
    .clk(clk),
    .wr_en_i(bus_wr_i && in_route),
    .wr_idx_i(bus_addr_i[EW-1:0]),
    .wdata_i(bus_wdata_i),
    .rd_idx_i(bus_addr_i[EW-1:0]),
    .rd_word_o(rd_word),
    .evt_i(evt_all),
    .hit_o(hit)
  );

  evdisp_chan_state #(.CH_N(P_CH_N)) u_state (
    .clk(clk), .rst_n(rst_n),
    .hit_i(hit),
    .clr_valid_i(clr_valid_i), .clr_ch_i(clr_ch_i),
    .err_rd_clr_i(err_rd_clr),
    .mask_wr_i(mask_wr), .mask_wdata_i(bus_wdata_i),
    .pend_o(pend_o), .err_o(err), .mask_o(mask), .irq_o(irq_o)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd_i) begin
      if (in_route)                  rdata_d = rd_word;
      else if (bus_addr_i == A_PEND) rdata_d = pend_o;
      else if (bus_addr_i == A_ERR)  rdata_d = err;
      else if (bus_addr_i == A_MASK) rdata_d = mask;
      else                           rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

  // An error read returns what was latched before the clear (R5)
  assert_err_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_rd_clr |=> (bus_rdata_o == $past(err)));
endmodule

// File: tb/evdisp_matrix_bench.sv
module evdisp_matrix_bench;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] evt_i = '0;
  logic [1:0]  pin_i = '0;
  logic        clr_valid_i = 1'b0;
  logic [4:0]  clr_ch_i = '0;
  logic [6:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_rdata_o, pend_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evdisp_matrix u_evdisp_matrix (
    .clk, .rst_n, .evt_i, .pin_i, .clr_valid_i, .clr_ch_i,
    .bus_addr_i, .bus_wr_i, .bus_wdata_i, .bus_rd_i,
    .bus_rdata_o, .pend_o, .irq_o
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic fire(input logic [47:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic clr(input int ch);
    @(negedge clk);
    clr_valid_i = 1'b1; clr_ch_i = 5'(ch);
    @(negedge clk);
    clr_valid_i = 1'b0;
  endtask

  task automatic clear_all();
    logic [31:0] d;
    for (int c = 0; c < 32; c++) if (pend_o[c]) clr(c);
    bus_rd(7'h41, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(pend_o == 0, "R1 pend", pend_o, 0);
    chk(irq_o == 0, "R1 irq", {31'd0, irq_o}, 0);
    chk(bus_rdata_o == 0, "R1 rdata", bus_rdata_o, 0);
    bus_rd(7'h41, d); chk(d == 0, "R1 err", d, 0);
    bus_rd(7'h42, d); chk(d == 0, "R1 mask", d, 0);
  endtask

  task automatic t_route_rw();
    logic [31:0] d;
    for (int e = 0; e < 48; e++) bus_wr(7'(e), 32'h0);
    bus_wr(7'd0, 32'hA5A5_0F0F);
    bus_wr(7'd47, 32'h8000_0001);
    bus_rd(7'd0, d);  chk(d == 32'hA5A5_0F0F, "R2 word0", d, 32'hA5A5_0F0F);
    bus_rd(7'd47, d); chk(d == 32'h8000_0001, "R2 word47", d, 32'h8000_0001);
    bus_rd(7'd20, d); chk(d == 0, "R2 word20", d, 0);
  endtask

  task automatic t_fanout();
    logic [31:0] d;
    bus_wr(7'd3, 32'h0000_1248);
    fire(48'd1 << 3);
    chk(pend_o == 32'h0000_1248, "R3 fanout", pend_o, 32'h0000_1248);
    bus_rd(7'h40, d); chk(d == 32'h0000_1248, "R11 pend read", d, 32'h0000_1248);
    bus_rd(7'h41, d); chk(d == 0, "R4 no error on fresh set", d, 0);
    fire(48'd1 << 47);
    chk(pend_o == 32'h8000_1249, "R3 second event", pend_o, 32'h8000_1249);
    clear_all();
  endtask

  task automatic t_clear();
    bus_wr(7'd5, 32'hFFFF_FFFF);
    fire(48'd1 << 5);
    clr(7);
    chk(pend_o == 32'hFFFF_FF7F, "R8 single clear", pend_o, 32'hFFFF_FF7F);
    clear_all();
    chk(pend_o == 0, "R8 all cleared", pend_o, 0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    bus_wr(7'd6, 32'h0000_0010);
    fire(48'd1 << 6);
    fire(48'd1 << 6);
    chk(pend_o == 32'h10, "R4 pend stays", pend_o, 32'h10);
    bus_rd(7'h41, d); chk(d == 32'h10, "R4 error latched", d, 32'h10);
    bus_rd(7'h41, d); chk(d == 0, "R5 read clears", d, 0);
    fire(48'd1 << 6);
    repeat (3) @(negedge clk);
    bus_rd(7'h41, d); chk(d == 32'h10, "R5 sticky until read", d, 32'h10);
    clear_all();
  endtask

  task automatic t_race_read();
    logic [31:0] d;
    bus_wr(7'd8, 32'h0000_0008);
    bus_wr(7'd9, 32'h0000_0020);
    fire(48'd1 << 8); fire(48'd1 << 8);
    fire(48'd1 << 9);
    @(negedge clk);
    bus_addr_i = 7'h41; bus_rd_i = 1'b1; evt_i = 48'd1 << 9;
    @(negedge clk);
    bus_rd_i = 1'b0; evt_i = '0;
    chk(bus_rdata_o == 32'h8, "R6 read shows old", bus_rdata_o, 32'h8);
    bus_rd(7'h41, d); chk(d == 32'h20, "R6 new error kept", d, 32'h20);
    clear_all();
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    bus_wr(7'd10, 32'h0000_0004);
    bus_wr(7'h42, 32'h0000_0001);
    bus_rd(7'h42, d); chk(d == 32'h1, "R7 mask read", d, 32'h1);
    fire(48'd1 << 10); fire(48'd1 << 10);
    chk(irq_o == 0, "R7 masked off", {31'd0, irq_o}, 0);
    bus_wr(7'h42, 32'h0000_0005);
    chk(irq_o == 1, "R7 irq on", {31'd0, irq_o}, 1);
    bus_rd(7'h41, d);
    chk(irq_o == 0, "R7 irq drops after read", {31'd0, irq_o}, 0);
    bus_wr(7'h42, 32'h0);
    clear_all();
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    bus_wr(7'd11, 32'h0000_0100);
    @(negedge clk);
    evt_i = 48'd1 << 11; clr_valid_i = 1'b1; clr_ch_i = 5'd8;
    @(negedge clk);
    evt_i = '0; clr_valid_i = 1'b0;
    chk(pend_o == 32'h100, "R9 set wins over clear", pend_o, 32'h100);
    bus_rd(7'h41, d); chk(d == 0, "R9 no error when was clear", d, 0);
    @(negedge clk);
    evt_i = 48'd1 << 11; clr_valid_i = 1'b1; clr_ch_i = 5'd8;
    @(negedge clk);
    evt_i = '0; clr_valid_i = 1'b0;
    chk(pend_o == 32'h100, "R9 set wins again", pend_o, 32'h100);
    bus_rd(7'h41, d); chk(d == 32'h100, "R9 error when was set", d, 32'h100);
    clear_all();
  endtask

  task automatic t_multi();
    logic [31:0] d;
    bus_wr(7'd20, 32'h0000_0200);
    bus_wr(7'd21, 32'h0000_0200);
    bus_wr(7'd22, 32'h0000_0201);
    fire((48'd1 << 20) | (48'd1 << 21) | (48'd1 << 22));
    chk(pend_o == 32'h201, "R12 multi set", pend_o, 32'h201);
    bus_rd(7'h41, d); chk(d == 0, "R12 no error", d, 0);
    clear_all();
  endtask

  task automatic t_pins();
    logic [31:0] d;
    bus_wr(7'd14, 32'h0010_0000);
    bus_wr(7'd15, 32'h0020_0000);
    @(negedge clk); pin_i = 2'b01;
    @(negedge clk); @(negedge clk);
    chk(pend_o == 0, "R10 not yet after two edges", pend_o, 0);
    @(negedge clk);
    chk(pend_o == 32'h0010_0000, "R10 set on third edge", pend_o, 32'h0010_0000);
    clr(20);
    repeat (6) @(negedge clk);
    chk(pend_o == 0, "R10 held high fires once", pend_o, 0);
    pin_i = 2'b10;
    repeat (6) @(negedge clk);
    chk(pend_o == 32'h0020_0000, "R10 pin1 rise, pin0 fall silent", pend_o, 32'h0020_0000);
    bus_rd(7'h41, d); chk(d == 0, "R10 no error", d, 0);
    pin_i = 2'b00;
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route_rw();
    t_fanout();
    t_clear();
    t_overrun();
    t_race_read();
    t_mask_irq();
    t_set_clear();
    t_multi();
    t_pins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule